// File: doc/BRIEF.md
# Peer Setup Message Decoder

This block turns the byte-wide control stream from a shared-memory coordination server into peer-table updates and interrupt-vector enables. Bytes arrive with a valid/ready handshake. Each group of eight bytes forms one signed 64-bit little-endian message. A one-bit handle flag travels alongside the final byte of each message and says whether an out-of-band handle came with it.

Setup runs in a fixed order. The first message is the protocol version and the second is this node's own ID. After that come any number of connect and disconnect messages, until the shared-memory message (value -1, with a handle) closes setup. After setup the block keeps accepting connect and disconnect messages. It counts vectors per peer: each connect takes the next vector number for its peer. A connect addressed to the own ID raises a one-cycle enable pulse that carries that vector number. Every rejected message gives a one-cycle error pulse with a code. An error during setup leaves the block in a failed state until reset. A peer ID beyond the table's build-time capacity sets a sticky overflow flag.

Top module: `peer_setup_decoder`

## Requirements
- R1: A message is eight accepted bytes, and the first byte accepted is the least significant. `in_handle` is sampled together with the eighth byte. The decision on a message appears on the registered outputs (`err_valid`/`err_code`, `vec_en`/`vec_num`) as a single-cycle pulse one clock after the eighth byte is accepted.
- R2: The first message must equal the parameter PROTO_VERSION and carry no handle. Otherwise `setup_failed` rises and error code 1 is pulsed.
- R3: The second message must lie in 0..65535 and carry no handle. If so, it becomes `own_id`. Otherwise setup fails with code 2.
- R4: `master_mode` is sampled with the ID message: 0 means off, 1 means forced, 2 or 3 means automatic. In forced mode a nonzero own ID fails setup with code 3. `is_master` is 1 when the mode is forced, or when the mode is automatic and the own ID is 0.
- R5: After the ID, a message below -1 or above 65535 is rejected with code 4. During setup this rejection fails setup. After setup it only reports the error.
- R6: Value -1 with a handle during setup raises `setup_done`. A later -1, or any -1 without a handle, is rejected with code 5.
- R7: A message in 0..65535 with a handle is a connect. The peer's count rises by one, and the vector assigned is the count before the increment. If the peer equals the own ID, `vec_en` pulses with `vec_num` set to that vector.
- R8: A connect to a peer whose count already equals NUM_VECTORS is rejected with code 6 and leaves the count unchanged.
- R9: A message in 0..65535 without a handle is a disconnect and sets the peer's count to 0. It is rejected with code 7 if the peer is not below the current table size or equals the own ID.
- R10: `tbl_size` resets to INIT_PEERS (16). A connect to a peer at or above it grows `tbl_size` to peer+1. The size never shrinks.
- R11: A peer ID at or above MAX_PEERS is rejected with code 8. It sets the sticky `overflow` flag and leaves the table unchanged.
- R12: Once `setup_failed` is set, `in_ready` is low, no pulses occur and the table does not change until reset.
- R13: After reset, `in_ready` is 1 and `setup_done`, `setup_failed`, `is_master` and `overflow` are 0. All counts read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| in_data | input | 8 | Stream byte |
| in_handle | input | 1 | Handle flag, sampled with the eighth byte |
| master_mode | input | 2 | 0 off, 1 forced, 2/3 automatic |
| qry_peer | input | $clog2(MAX_PEERS) | Peer index for count readout |
| qry_count | output | $clog2(NUM_VECTORS+1) | Vector count of qry_peer |
| tbl_size | output | $clog2(MAX_PEERS+1) | Current peer table size |
| setup_done | output | 1 | Shared-memory message received |
| setup_failed | output | 1 | Setup error, sticky until reset |
| own_id | output | 16 | Own ID from the second message |
| is_master | output | 1 | Master selection |
| err_valid | output | 1 | One-cycle rejection pulse |
| err_code | output | 4 | Rejection code (R2-R11) |
| vec_en | output | 1 | One-cycle own-vector enable pulse |
| vec_num | output | max(1,$clog2(NUM_VECTORS)) | Vector number for vec_en |
| overflow | output | 1 | Sticky peer-capacity overflow |

## Verification
A stale byte counter shifts the message boundary. Every following message then decodes as garbage and gives range or version errors on the next pulse. A wrong peer count shows up at most one connect later, either as a missing or spurious code 6 or as a wrong `vec_num` on the own ID, and it is also visible at once through `qry_count`. A wrong setup state shows on `setup_done` or `setup_failed` one clock after the message that should have moved it. Its effect then persists through `in_ready` and through the code-5 and code-4 handling of later messages.

// File: rtl/peer_setup_pkg.sv
package peer_setup_pkg;

  typedef enum logic [2:0] {
    ST_VERSION = 3'd0,
    ST_OWNID   = 3'd1,
    ST_PEERS   = 3'd2,
    ST_RUN     = 3'd3,
    ST_FAIL    = 3'd4
  } setup_state_e;

  typedef enum logic [3:0] {
    EC_NONE     = 4'd0,
    EC_VERSION  = 4'd1,
    EC_OWNID    = 4'd2,
    EC_MASTER   = 4'd3,
    EC_RANGE    = 4'd4,
    EC_SHMEM    = 4'd5,
    EC_FULL     = 4'd6,
    EC_DISCONN  = 4'd7,
    EC_OVERFLOW = 4'd8
  } err_code_e;

  localparam logic [1:0] MM_OFF    = 2'd0;
  localparam logic [1:0] MM_FORCED = 2'd1;

endpackage

// File: rtl/msg_assembler.sv
module msg_assembler (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic        accept_en,
  input  logic [7:0]  byte_data,
  input  logic        byte_handle,
  output logic        msg_vld,
  output logic [63:0] msg_data,
  output logic        msg_hdl
);

  logic [2:0]  idx_q, idx_d;
  logic [63:0] shreg_q, shreg_d;
  logic        vld_d, hdl_d, take;

  assign take = byte_valid && accept_en;

  always_comb begin
    idx_d   = idx_q;
    shreg_d = shreg_q;
    vld_d   = 1'b0;
    hdl_d   = msg_hdl;
    if (take) begin
      idx_d   = idx_q + 3'd1;
      shreg_d = {byte_data, shreg_q[63:8]};
      if (idx_q == 3'd7) begin
        vld_d = 1'b1;
        hdl_d = byte_handle;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      shreg_q <= '0;
      msg_vld <= 1'b0;
      msg_hdl <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      msg_vld <= vld_d;
      msg_hdl <= hdl_d;
    end
  end

  assign msg_data = shreg_q;

  // R1
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_vld |=> !msg_vld);

  // R12
  blocked_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_en |=> !msg_vld);

endmodule

// File: rtl/peer_count_table.sv
module peer_count_table #(
  parameter int MAX_PEERS   = 32,
  parameter int INIT_PEERS  = 16,
  parameter int NUM_VECTORS = 1,
  localparam int IDW = $clog2(MAX_PEERS),
  localparam int CW  = $clog2(NUM_VECTORS + 1),
  localparam int SW  = $clog2(MAX_PEERS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] op_peer,
  input  logic           grow_en,
  input  logic           inc_en,
  input  logic           clr_en,
  output logic [CW-1:0]  op_count,
  input  logic [IDW-1:0] qry_peer,
  output logic [CW-1:0]  qry_count,
  output logic [SW-1:0]  size
);

  localparam logic [CW-1:0] VEC_LIM = CW'(NUM_VECTORS);

  logic [CW-1:0] cnt_q [MAX_PEERS];
  logic [SW-1:0] size_d;

  genvar gi;
  generate
    for (gi = 0; gi < MAX_PEERS; gi++) begin : g_entry
      logic          sel, ld;
      logic [CW-1:0] nxt;
      assign sel = (op_peer == IDW'(gi));
      assign ld  = sel && (inc_en || clr_en);
      assign nxt = clr_en ? '0 : cnt_q[gi] + CW'(1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cnt_q[gi] <= '0;
        else if (ld) cnt_q[gi] <= nxt;
      end
      // R8
      count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[gi] <= VEC_LIM);
    end
  endgenerate

  always_comb begin
    size_d = size;
    if (grow_en && (SW'(op_peer) >= size)) size_d = SW'(op_peer) + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size <= SW'(INIT_PEERS);
    else        size <= size_d;
  end

  assign op_count  = cnt_q[op_peer];
  assign qry_count = cnt_q[qry_peer];

  // R10
  size_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size >= $past(size));

endmodule

// File: rtl/setup_sequencer.sv
module setup_sequencer
  import peer_setup_pkg::*;
#(
  parameter int MAX_PEERS     = 32,
  parameter int NUM_VECTORS   = 1,
  parameter int PROTO_VERSION = 0,
  localparam int IDW = $clog2(MAX_PEERS),
  localparam int CW  = $clog2(NUM_VECTORS + 1),
  localparam int SW  = $clog2(MAX_PEERS + 1),
  localparam int VW  = (NUM_VECTORS > 1) ? $clog2(NUM_VECTORS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           msg_vld,
  input  logic [63:0]    msg_data,
  input  logic           msg_hdl,
  input  logic [1:0]     master_mode,
  input  logic [CW-1:0]  cur_count,
  input  logic [SW-1:0]  cur_size,
  output logic [IDW-1:0] tbl_peer,
  output logic           grow_en,
  output logic           inc_en,
  output logic           clr_en,
  output logic           accept_en,
  output logic           setup_done,
  output logic           setup_failed,
  output logic [15:0]    own_id,
  output logic           is_master,
  output logic           err_valid,
  output logic [3:0]     err_code,
  output logic           vec_en,
  output logic [VW-1:0]  vec_num,
  output logic           overflow
);

  localparam logic [63:0]   VER_W   = 64'(PROTO_VERSION);
  localparam logic [16:0]   CAP_W   = 17'(MAX_PEERS);
  localparam logic [CW-1:0] VEC_LIM = CW'(NUM_VECTORS);

  setup_state_e  st_q, st_d;
  err_code_e     ec_d;
  logic          own_ld, mst_d, ven_d, ovf_d;
  logic [VW-1:0] vnum_d;
  logic [15:0]   pid;
  logic          in_rng, is_neg1, beyond_cap, beyond_size;

  assign pid         = msg_data[15:0];
  assign in_rng      = (msg_data[63:16] == '0);
  assign is_neg1     = &msg_data;
  assign beyond_cap  = {1'b0, pid} >= CAP_W;
  assign beyond_size = {1'b0, pid} >= 17'(cur_size);
  assign tbl_peer    = pid[IDW-1:0];

  always_comb begin
    st_d    = st_q;
    ec_d    = EC_NONE;
    own_ld  = 1'b0;
    mst_d   = is_master;
    ven_d   = 1'b0;
    vnum_d  = vec_num;
    ovf_d   = overflow;
    grow_en = 1'b0;
    inc_en  = 1'b0;
    clr_en  = 1'b0;
    if (msg_vld) begin
      unique case (st_q)
        ST_VERSION: begin
          if (msg_data == VER_W && !msg_hdl) st_d = ST_OWNID;
          else                               ec_d = EC_VERSION;
        end
        ST_OWNID: begin
          if (in_rng && !msg_hdl) begin
            own_ld = 1'b1;
            mst_d  = (master_mode == MM_FORCED) ||
                     (master_mode[1] && pid == 16'd0);
            if (master_mode == MM_FORCED && pid != 16'd0) ec_d = EC_MASTER;
            else                                          st_d = ST_PEERS;
          end else begin
            ec_d = EC_OWNID;
          end
        end
        ST_PEERS, ST_RUN: begin
          if (is_neg1) begin
            if (msg_hdl && st_q == ST_PEERS) st_d = ST_RUN;
            else                             ec_d = EC_SHMEM;
          end else if (!in_rng) begin
            ec_d = EC_RANGE;
          end else if (beyond_cap) begin
            ec_d  = EC_OVERFLOW;
            ovf_d = 1'b1;
          end else if (msg_hdl) begin
            grow_en = 1'b1;
            if (cur_count >= VEC_LIM) begin
              ec_d = EC_FULL;
            end else begin
              inc_en = 1'b1;
              if (pid == own_id) begin
                ven_d  = 1'b1;
                vnum_d = cur_count[VW-1:0];
              end
            end
          end else begin
            if (beyond_size || pid == own_id) ec_d = EC_DISCONN;
            else                              clr_en = 1'b1;
          end
        end
        default: ;
      endcase
      if (ec_d != EC_NONE && st_q != ST_RUN) st_d = ST_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_VERSION;
      own_id    <= '0;
      is_master <= 1'b0;
      err_valid <= 1'b0;
      err_code  <= '0;
      vec_en    <= 1'b0;
      vec_num   <= '0;
      overflow  <= 1'b0;
    end else begin
      st_q      <= st_d;
      is_master <= mst_d;
      err_valid <= (ec_d != EC_NONE);
      err_code  <= ec_d;
      vec_en    <= ven_d;
      vec_num   <= vnum_d;
      overflow  <= ovf_d;
      if (own_ld) own_id <= pid;
    end
  end

  assign accept_en    = (st_q != ST_FAIL);
  assign setup_failed = (st_q == ST_FAIL);
  assign setup_done   = (st_q == ST_RUN);

  // R12
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_failed |=> setup_failed);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> setup_done);

  // R7
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_valid && vec_en));

  // R11
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R1
  decision_needs_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid || vec_en) |-> $past(msg_vld));

endmodule

// File: rtl/peer_setup_decoder.sv
module peer_setup_decoder #(
  parameter int MAX_PEERS     = 32,
  parameter int INIT_PEERS    = 16,
  parameter int NUM_VECTORS   = 1,
  parameter int PROTO_VERSION = 0,
  localparam int IDW = $clog2(MAX_PEERS),
  localparam int CW  = $clog2(NUM_VECTORS + 1),
  localparam int SW  = $clog2(MAX_PEERS + 1),
  localparam int VW  = (NUM_VECTORS > 1) ? $clog2(NUM_VECTORS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_handle,
  input  logic [1:0]     master_mode,
  input  logic [IDW-1:0] qry_peer,
  output logic [CW-1:0]  qry_count,
  output logic [SW-1:0]  tbl_size,
  output logic           setup_done,
  output logic           setup_failed,
  output logic [15:0]    own_id,
  output logic           is_master,
  output logic           err_valid,
  output logic [3:0]     err_code,
  output logic           vec_en,
  output logic [VW-1:0]  vec_num,
  output logic           overflow
);

  logic           rs_meta, rs_n;
  logic           m_vld, m_hdl;
  logic [63:0]    m_data;
  logic [IDW-1:0] t_peer;
  logic           t_grow, t_inc, t_clr;
  logic [CW-1:0]  t_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  msg_assembler u_asm (
    .clk         (clk),
    .rst_n       (rs_n),
    .byte_valid  (in_valid),
    .accept_en   (in_ready),
    .byte_data   (in_data),
    .byte_handle (in_handle),
    .msg_vld     (m_vld),
    .msg_data    (m_data),
    .msg_hdl     (m_hdl)
  );

  peer_count_table #(
    .MAX_PEERS   (MAX_PEERS),
    .INIT_PEERS  (INIT_PEERS),
    .NUM_VECTORS (NUM_VECTORS)
  ) u_tbl (
    .clk       (clk),
    .rst_n     (rs_n),
    .op_peer   (t_peer),
    .grow_en   (t_grow),
    .inc_en    (t_inc),
    .clr_en    (t_clr),
    .op_count  (t_count),
    .qry_peer  (qry_peer),
    .qry_count (qry_count),
    .size      (tbl_size)
  );

  setup_sequencer #(
    .MAX_PEERS     (MAX_PEERS),
    .NUM_VECTORS   (NUM_VECTORS),
    .PROTO_VERSION (PROTO_VERSION)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rs_n),
    .msg_vld      (m_vld),
    .msg_data     (m_data),
    .msg_hdl      (m_hdl),
    .master_mode  (master_mode),
    .cur_count    (t_count),
    .cur_size     (tbl_size),
    .tbl_peer     (t_peer),
    .grow_en      (t_grow),
    .inc_en       (t_inc),
    .clr_en       (t_clr),
    .accept_en    (in_ready),
    .setup_done   (setup_done),
    .setup_failed (setup_failed),
    .own_id       (own_id),
    .is_master    (is_master),
    .err_valid    (err_valid),
    .err_code     (err_code),
    .vec_en       (vec_en),
    .vec_num      (vec_num),
    .overflow     (overflow)
  );

endmodule

// File: tb/peer_setup_decoder_tb_top.sv
module peer_setup_decoder_tb_top;

  localparam int MAXP = 32;
  localparam int NV   = 2;
  localparam int NTV  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_handle = 1'b0;
  logic [1:0] master_mode = 2'd2;
  logic [4:0] qry_peer = '0;
  logic       in_ready, setup_done, setup_failed, is_master;
  logic       err_valid, vec_en, overflow;
  logic [1:0] qry_count;
  logic [5:0] tbl_size;
  logic [15:0] own_id;
  logic [3:0] err_code;
  logic [0:0] vec_num;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  peer_setup_decoder #(
    .MAX_PEERS(MAXP), .INIT_PEERS(16), .NUM_VECTORS(NV), .PROTO_VERSION(0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_handle(in_handle), .master_mode(master_mode),
    .qry_peer(qry_peer), .qry_count(qry_count), .tbl_size(tbl_size),
    .setup_done(setup_done), .setup_failed(setup_failed), .own_id(own_id),
    .is_master(is_master), .err_valid(err_valid), .err_code(err_code),
    .vec_en(vec_en), .vec_num(vec_num), .overflow(overflow)
  );

  // {msg, handle, err_code, vec_en, vec_num}, applied after setup with own ID 3
  localparam logic [70:0] TV [NTV] = '{
    {64'd3,     1'b1, 4'd0, 1'b1, 1'b1},
    {64'd3,     1'b1, 4'd6, 1'b0, 1'b0},
    {64'd1,     1'b1, 4'd0, 1'b0, 1'b0},
    {64'd1,     1'b1, 4'd6, 1'b0, 1'b0},
    {64'd1,     1'b0, 4'd0, 1'b0, 1'b0},
    {64'd1,     1'b1, 4'd0, 1'b0, 1'b0},
    {64'd3,     1'b0, 4'd7, 1'b0, 1'b0},
    {64'd20,    1'b0, 4'd7, 1'b0, 1'b0},
    {64'd20,    1'b1, 4'd0, 1'b0, 1'b0},
    {64'd40,    1'b1, 4'd8, 1'b0, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd5, 1'b0, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd5, 1'b0, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 4'd4, 1'b0, 1'b0},
    {64'd65536, 1'b1, 4'd4, 1'b0, 1'b0},
    {64'd65535, 1'b1, 4'd8, 1'b0, 1'b0},
    {64'd0,     1'b1, 4'd0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Sends one message; returns at the negedge where its decision pulse is visible.
  task automatic send_msg(input logic [63:0] v, input logic h);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = v[8*i +: 8];
      in_handle = (i == 7) ? h : 1'b0;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_handle = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_pulse(input string tag, input logic [3:0] ec, input logic ve, input logic vn);
    check({tag, " err_valid"}, err_valid, ec != 0);
    check({tag, " err_code"}, err_code, ec);
    check({tag, " vec_en"}, vec_en, ve);
    if (ve) check({tag, " vec_num"}, vec_num, vn);
  endtask

  task automatic peek(input string tag, input int p, input int exp);
    qry_peer = 5'(p);
    #1;
    check(tag, qry_count, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R13 reset state
    check("R13 in_ready", in_ready, 1);
    check("R13 setup_done", setup_done, 0);
    check("R13 setup_failed", setup_failed, 0);
    check("R13 is_master", is_master, 0);
    check("R13 overflow", overflow, 0);
    check("R10 initial size", tbl_size, 16);
    peek("R13 count peer1", 1, 0);

    // Setup: version, own ID 3, peer connects, shared memory
    send_msg(64'd0, 1'b0);
    expect_pulse("R2 version ok", 0, 0, 0);
    send_msg(64'd3, 1'b0);
    expect_pulse("R3 own id ok", 0, 0, 0);
    check("R3 own_id", own_id, 3);
    check("R4 auto nonzero id", is_master, 0);
    send_msg(64'd1, 1'b1);
    expect_pulse("R7 setup peer connect", 0, 0, 0);
    send_msg(64'd3, 1'b1);
    expect_pulse("R7 own connect vector 0", 0, 1, 0);
    check("R6 not done before shm", setup_done, 0);
    send_msg(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    expect_pulse("R6 shm msg", 0, 0, 0);
    check("R6 setup_done", setup_done, 1);

    // Table of run-phase messages (R5 R6 R7 R8 R9 R10 R11)
    for (int k = 0; k < NTV; k++) begin
      send_msg(TV[k][70:7], TV[k][6]);
      expect_pulse($sformatf("R5-vector %0d", k), TV[k][5:2], TV[k][1], TV[k][0]);
    end
    peek("R9 peer1 after reconnect", 1, 1);
    peek("R8 peer3 full kept", 3, 2);
    peek("R10 peer20 count", 20, 1);
    peek("R7 peer0 count", 0, 1);
    check("R10 grown size", tbl_size, 21);
    check("R11 overflow flag", overflow, 1);
    check("R5 not failed after run error", setup_failed, 0);

    // R2 bad version
    do_reset();
    send_msg(64'd5, 1'b0);
    expect_pulse("R2 bad version", 1, 0, 0);
    check("R2 failed", setup_failed, 1);
    check("R12 in_ready low", in_ready, 0);
    send_msg(64'd0, 1'b0);
    expect_pulse("R12 ignored", 0, 0, 0);
    check("R12 size unchanged", tbl_size, 16);
    check("R12 still failed", setup_failed, 1);

    // R2 version with handle
    do_reset();
    send_msg(64'd0, 1'b1);
    expect_pulse("R2 version handle", 1, 0, 0);

    // R3 own id out of range
    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(64'd70000, 1'b0);
    expect_pulse("R3 id range", 2, 0, 0);
    check("R3 failed", setup_failed, 1);

    // R4 forced master with nonzero id
    do_reset();
    master_mode = 2'd1;
    send_msg(64'd0, 1'b0);
    send_msg(64'd2, 1'b0);
    expect_pulse("R4 forced nonzero", 3, 0, 0);
    check("R4 failed", setup_failed, 1);

    do_reset();
    send_msg(64'd0, 1'b0);
    send_msg(64'd0, 1'b0);
    expect_pulse("R4 forced zero", 0, 0, 0);
    check("R4 forced master", is_master, 1);

    // R4 auto with id 0, then R5 range error during setup fails
    do_reset();
    master_mode = 2'd2;
    send_msg(64'd0, 1'b0);
    send_msg(64'd0, 1'b0);
    check("R4 auto master", is_master, 1);
    send_msg(64'hFFFF_FFFF_FFFF_FFFB, 1'b0);
    expect_pulse("R5 setup range", 4, 0, 0);
    check("R5 setup failed", setup_failed, 1);

    // R4 off mode
    do_reset();
    master_mode = 2'd0;
    send_msg(64'd0, 1'b0);
    send_msg(64'd0, 1'b0);
    check("R4 off mode", is_master, 0);
    // R6 shm without handle during setup
    send_msg(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    expect_pulse("R6 shm without handle", 5, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule